// File: doc/BRIEF.md
# Branch Target Buffer

This block predicts where instruction fetch goes next while a branch is still being fetched. Each cycle the front end presents a fetch address together with a one-bit taken/not-taken hint from a separate direction predictor. The buffer is a small set-associative store. Each entry holds the upper bits of a branch address and the target that branch last jumped to. If the fetch address matches an entry and the hint says taken, the stored target becomes the predicted next fetch address. In every other case the prediction is the sequential address, fetch address plus four. An address that is not in the buffer is always treated as not taken.

Resolved branches from the back end train the buffer through a separate update port. A taken branch that is not in the buffer gets an entry. A not-taken branch that is not in the buffer is never given one, so capacity goes only to branches that have actually jumped. A branch already in the buffer has its target rewritten when it resolves taken. Within a set, the victim is the least recently used way. Both a lookup hit and an update touch that recency state.

The prediction is registered and appears one cycle after the fetch address is presented.

Top module: `btb_top`

## Requirements
- R1: While reset is high, and in the cycle after it falls, `pred_valid` and `pred_hit` are 0. Reset invalidates every entry, so after reset each lookup misses until an entry has been allocated.
- R2: A lookup that misses gives `pred_hit`=0 and `pred_next_pc` = fetch address + 4, modulo 2^PC_W.
- R3: A lookup that hits while `fetch_dir_taken`=1 gives `pred_hit`=1 and `pred_next_pc` = the stored target.
- R4: A lookup that hits while `fetch_dir_taken`=0 gives `pred_hit`=1 and `pred_next_pc` = fetch address + 4.
- R5: An update that misses allocates an entry only if `upd_taken`=1. An update that misses with `upd_taken`=0 leaves the buffer unchanged.
- R6: An update with `upd_taken`=1 that hits an existing entry replaces that entry's target with `upd_target`.
- R7: Each set holds two ways, so two branches with the same set index can both hit. No address ever matches more than one way.
- R8: When a taken miss is allocated into a full set, the way evicted is the one least recently touched, where a lookup hit or an update counts as a touch. If a set has an empty way, allocation uses it first.
- R9: Every prediction is registered. `pred_valid` equals `fetch_valid` from the previous cycle, and `pred_hit` and `pred_next_pc` describe the lookup made in that cycle.
- R10: A lookup and an update in the same cycle are resolved as follows. The lookup sees the buffer as it was before the update. A lookup hit in the same set is counted as a touch before the update chooses its victim, and the update's touch is the final one.
- R11: The set index is address bits [4:2]. The tag is bits [PC_W-1:5]. Address bits [1:0] have no effect on matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A lookup is requested this cycle |
| fetch_pc | input | PC_W | Fetch address to look up |
| fetch_dir_taken | input | 1 | Direction hint that gates use of a hit |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | PC_W | Resolved target address |
| pred_valid | output | 1 | Registered: the prediction below is meaningful |
| pred_hit | output | 1 | Registered: the lookup matched an entry |
| pred_next_pc | output | PC_W | Registered predicted next fetch address |

## Verification
Internal state is only visible through later lookups. A corrupted valid bit, tag or target shows up one cycle after the next lookup of that set, as a wrong `pred_hit` or a wrong target. A wrong recency bit stays hidden until a third branch is allocated into a full set. It then appears as a miss on a branch that should have survived, so the bench deliberately touches ways and then forces evictions. A behavioural recency-list model checks every cycle of directed and randomised traffic, including lookups and updates in the same set during the same cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned BTB_WAYS = 2;

  typedef enum logic [1:0] {
    UPD_NONE     = 2'd0,
    UPD_REFRESH  = 2'd1,
    UPD_RETARGET = 2'd2,
    UPD_ALLOC    = 2'd3
  } upd_kind_e;
endpackage

// File: rtl/btb_way_store.sv
module btb_way_store #(
  parameter int unsigned SETS  = 8,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned TAG_W = 27,
  parameter int unsigned PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PC_W-1:0]  lk_tgt,
  input  logic [IDX_W-1:0] up_idx,
  input  logic [TAG_W-1:0] up_tag,
  output logic             up_hit,
  output logic             up_vld,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PC_W-1:0]  wr_tgt
);
  logic [SETS-1:0]  valid_q;
  logic [TAG_W-1:0] tag_mem [SETS];
  logic [PC_W-1:0]  tgt_mem [SETS];

  // valid bits are the only state that reset clears
  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  // tag and target arrays carry no reset so they can map to RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_tgt;
    end
  end

  assign lk_hit = valid_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);
  assign lk_tgt = tgt_mem[lk_idx];
  assign up_vld = valid_q[up_idx];
  assign up_hit = valid_q[up_idx] && (tag_mem[up_idx] == up_tag);
endmodule

// File: rtl/btb_lru.sv
module btb_lru #(
  parameter int unsigned SETS  = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_en,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic             lk_way,
  input  logic             up_en,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_way,
  output logic             up_lru
);
  // one bit per set naming the way to evict next
  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lru_q <= '0;
    end else begin
      for (int s = 0; s < int'(SETS); s++) begin
        if (up_en && up_idx == IDX_W'(s))      lru_q[s] <= ~up_way;
        else if (lk_en && lk_idx == IDX_W'(s)) lru_q[s] <= ~lk_way;
      end
    end
  end

  assign up_lru = lru_q[up_idx];
endmodule

// File: rtl/btb_next_pc.sv
module btb_next_pc #(
  parameter int unsigned PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            dir_taken,
  input  logic            hit,
  input  logic [PC_W-1:0] hit_tgt,
  output logic            pred_valid,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_next_pc
);
  logic [PC_W-1:0] seq_pc;
  assign seq_pc = fetch_pc + PC_W'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid   <= 1'b0;
      pred_hit     <= 1'b0;
      pred_next_pc <= '0;
    end else begin
      pred_valid <= fetch_valid;
      pred_hit   <= fetch_valid && hit;
      if (fetch_valid) pred_next_pc <= (hit && dir_taken) ? hit_tgt : seq_pc;
    end
  end
endmodule

// File: rtl/btb_top.sv
module btb_top
  import btb_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            fetch_dir_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  output logic            pred_valid,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_next_pc
);
  localparam int unsigned SETS  = 1 << IDX_W;
  localparam int unsigned LO_W  = 2;
  localparam int unsigned TAG_W = PC_W - IDX_W - LO_W;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             unused_lo;

  assign lk_idx    = fetch_pc[LO_W +: IDX_W];
  assign lk_tag    = fetch_pc[PC_W-1 -: TAG_W];
  assign up_idx    = upd_pc[LO_W +: IDX_W];
  assign up_tag    = upd_pc[PC_W-1 -: TAG_W];
  assign unused_lo = ^upd_pc[LO_W-1:0];

  logic [BTB_WAYS-1:0] lk_hit_w, up_hit_w, up_vld_w, wr_en_w;
  logic [PC_W-1:0]     lk_tgt_w [BTB_WAYS];

  logic      wr_way;
  upd_kind_e upd_kind;

  for (genvar w = 0; w < int'(BTB_WAYS); w++) begin : g_way
    assign wr_en_w[w] = (upd_kind == UPD_RETARGET || upd_kind == UPD_ALLOC)
                        && (wr_way == 1'(w));
    btb_way_store #(
      .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)
    ) u_store (
      .clk    (clk),
      .rst    (rst),
      .lk_idx (lk_idx),
      .lk_tag (lk_tag),
      .lk_hit (lk_hit_w[w]),
      .lk_tgt (lk_tgt_w[w]),
      .up_idx (up_idx),
      .up_tag (up_tag),
      .up_hit (up_hit_w[w]),
      .up_vld (up_vld_w[w]),
      .wr_en  (wr_en_w[w]),
      .wr_idx (up_idx),
      .wr_tag (up_tag),
      .wr_tgt (upd_target)
    );
  end

  // lookup side
  logic            lk_hit, lk_way;
  logic [PC_W-1:0] lk_tgt;
  assign lk_hit = fetch_valid && (|lk_hit_w);
  assign lk_way = lk_hit_w[1];
  assign lk_tgt = lk_hit_w[1] ? lk_tgt_w[1] : lk_tgt_w[0];

  // update side
  logic up_hit, up_hit_way, up_lru, eff_lru, victim;
  assign up_hit     = |up_hit_w;
  assign up_hit_way = up_hit_w[1];
  // a same-cycle lookup hit in this set is a touch that comes first
  assign eff_lru = (lk_hit && lk_idx == up_idx) ? ~lk_way : up_lru;

  always_comb begin
    if (!up_vld_w[0])      victim = 1'b0;
    else if (!up_vld_w[1]) victim = 1'b1;
    else                   victim = eff_lru;
  end

  always_comb begin
    upd_kind = UPD_NONE;
    if (upd_valid) begin
      if (up_hit)         upd_kind = upd_taken ? UPD_RETARGET : UPD_REFRESH;
      else if (upd_taken) upd_kind = UPD_ALLOC;
    end
  end

  assign wr_way = up_hit ? up_hit_way : victim;

  btb_lru #(.SETS(SETS), .IDX_W(IDX_W)) u_lru (
    .clk    (clk),
    .rst    (rst),
    .lk_en  (lk_hit),
    .lk_idx (lk_idx),
    .lk_way (lk_way),
    .up_en  (upd_kind != UPD_NONE),
    .up_idx (up_idx),
    .up_way (wr_way),
    .up_lru (up_lru)
  );

  btb_next_pc #(.PC_W(PC_W)) u_next (
    .clk          (clk),
    .rst          (rst),
    .fetch_valid  (fetch_valid),
    .fetch_pc     (fetch_pc),
    .dir_taken    (fetch_dir_taken),
    .hit          (lk_hit),
    .hit_tgt      (lk_tgt),
    .pred_valid   (pred_valid),
    .pred_hit     (pred_hit),
    .pred_next_pc (pred_next_pc)
  );
endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            fetch_valid,
  input logic [PC_W-1:0] fetch_pc,
  input logic            fetch_dir_taken,
  input logic            pred_valid,
  input logic            pred_hit,
  input logic [PC_W-1:0] pred_next_pc,
  input logic [1:0]      lk_hit_w,
  input logic [1:0]      wr_en_w
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!pred_valid && !pred_hit));

  // R9
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> pred_valid);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> (!pred_valid && !pred_hit));

  // R2
  miss_seq_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> (pred_hit || pred_next_pc == PC_W'($past(fetch_pc) + PC_W'(4))));

  // R4
  gated_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && !fetch_dir_taken) |=> (pred_next_pc == PC_W'($past(fetch_pc) + PC_W'(4))));

  // R7
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hit_w));

  // R7
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en_w));
endmodule

bind btb_top btb_chk #(.PC_W(PC_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .fetch_valid     (fetch_valid),
  .fetch_pc        (fetch_pc),
  .fetch_dir_taken (fetch_dir_taken),
  .pred_valid      (pred_valid),
  .pred_hit        (pred_hit),
  .pred_next_pc    (pred_next_pc),
  .lk_hit_w        (lk_hit_w),
  .wr_en_w         (wr_en_w)
);

// File: tb/btb_top_tb.sv
module btb_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W  = 32;
  localparam int IDX_W = 3;
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - 2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            fetch_valid = 1'b0, fetch_dir_taken = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            upd_valid = 1'b0, upd_taken = 1'b0;
  logic [PC_W-1:0] upd_pc = '0, upd_target = '0;
  logic            pred_valid, pred_hit;
  logic [PC_W-1:0] pred_next_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_top #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .fetch_dir_taken(fetch_dir_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_next_pc(pred_next_pc)
  );

  int    total = 0, bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural model: per set, a recency list with the most recent first
  typedef struct packed { logic [TAG_W-1:0] tag; logic [PC_W-1:0] tgt; } ent_t;
  ent_t            mq [SETS][$];
  logic            e_valid = 1'b0, e_hit = 1'b0;
  logic [PC_W-1:0] e_next = '0;

  function automatic int find(int s, logic [TAG_W-1:0] t);
    for (int i = 0; i < mq[s].size(); i++) if (mq[s][i].tag == t) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) mq[s].delete();
      e_valid = 1'b0; e_hit = 1'b0; e_next = '0;
    end else begin
      e_valid = fetch_valid;
      e_hit   = 1'b0;
      if (fetch_valid) begin
        int s, f;
        ent_t e;
        s = int'(fetch_pc[4:2]);
        f = find(s, fetch_pc[PC_W-1:5]);
        e_hit  = (f >= 0);
        e_next = fetch_pc + 4;
        if (f >= 0) begin
          e = mq[s][f];
          if (fetch_dir_taken) e_next = e.tgt;
          mq[s].delete(f);
          mq[s].push_front(e);
        end
      end
      if (upd_valid) begin
        int s, f;
        ent_t e;
        s = int'(upd_pc[4:2]);
        f = find(s, upd_pc[PC_W-1:5]);
        if (f >= 0) begin
          e = mq[s][f];
          if (upd_taken) e.tgt = upd_target;
          mq[s].delete(f);
          mq[s].push_front(e);
        end else if (upd_taken) begin
          e.tag = upd_pc[PC_W-1:5];
          e.tgt = upd_target;
          if (mq[s].size() == 2) void'(mq[s].pop_back());
          mq[s].push_front(e);
        end
      end
    end
  end

  // compare on every cycle, half a period away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (pred_valid !== e_valid || (e_valid && (pred_hit !== e_hit || pred_next_pc !== e_next))
          || (!e_valid && pred_hit !== 1'b0)) begin
        bad++;
        $display("FAIL %s: valid/hit/next=%0b/%0b/%h expected %0b/%0b/%h",
                 cur_req, pred_valid, pred_hit, pred_next_pc, e_valid, e_hit, e_next);
      end
    end
  end

  task automatic step(input logic fv, input logic [PC_W-1:0] fpc, input logic fd,
                      input logic uv, input logic [PC_W-1:0] upc, input logic ut,
                      input logic [PC_W-1:0] utg);
    @(negedge clk); #1;
    fetch_valid = fv; fetch_pc = fpc; fetch_dir_taken = fd;
    upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input logic tk, input logic [PC_W-1:0] tg);
    step(1'b0, '0, 1'b0, 1'b1, pc, tk, tg);
  endtask

  // direct check with constants taken from the requirements
  task automatic look(input string req, input logic [PC_W-1:0] pc, input logic dir,
                      input logic xh, input logic [PC_W-1:0] xn);
    cur_req = req;
    step(1'b1, pc, dir, 1'b0, '0, 1'b0, '0);
    @(posedge clk); #2;
    total++;
    if (pred_valid !== 1'b1 || pred_hit !== xh || pred_next_pc !== xn) begin
      bad++;
      $display("FAIL %s: pc=%h hit/next=%0b/%h expected %0b/%h",
               req, pc, pred_hit, pred_next_pc, xh, xn);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog: cycles=200000 expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(posedge clk);
    #2;
    total++;
    if (pred_valid !== 1'b0 || pred_hit !== 1'b0) begin
      bad++;
      $display("FAIL R1: valid/hit=%0b/%0b expected 0/0", pred_valid, pred_hit);
    end
    @(negedge clk); rst = 1'b0;

    look("R1", 32'h100, 1'b1, 1'b0, 32'h104);
    look("R2", 32'hFFFF_FFFC, 1'b1, 1'b0, 32'h0);
    cur_req = "R5"; upd(32'h100, 1'b0, 32'h500);
    look("R5", 32'h100, 1'b1, 1'b0, 32'h104);
    cur_req = "R5"; upd(32'h100, 1'b1, 32'h200);
    look("R3", 32'h100, 1'b1, 1'b1, 32'h200);
    look("R4", 32'h100, 1'b0, 1'b1, 32'h104);
    cur_req = "R6"; upd(32'h100, 1'b1, 32'h300);
    look("R6", 32'h100, 1'b1, 1'b1, 32'h300);
    cur_req = "R7"; upd(32'h120, 1'b1, 32'h400);
    look("R7", 32'h120, 1'b1, 1'b1, 32'h400);
    look("R7", 32'h100, 1'b1, 1'b1, 32'h300);
    look("R11", 32'h102, 1'b1, 1'b1, 32'h300);
    look("R11", 32'h104, 1'b1, 1'b0, 32'h108);
    // 0x100 was touched last, so a third branch in set 0 evicts 0x120
    cur_req = "R8"; upd(32'h140, 1'b1, 32'h600);
    look("R8", 32'h120, 1'b1, 1'b0, 32'h124);
    look("R8", 32'h100, 1'b1, 1'b1, 32'h300);
    look("R8", 32'h140, 1'b1, 1'b1, 32'h600);
    // same cycle: lookup of 0x140 (touch) and allocation of 0x160 -> 0x100 evicted
    cur_req = "R10";
    step(1'b1, 32'h140, 1'b1, 1'b1, 32'h160, 1'b1, 32'h700);
    step(1'b1, 32'h160, 1'b1, 1'b0, '0, 1'b0, '0);
    look("R10", 32'h100, 1'b1, 1'b0, 32'h104);
    look("R10", 32'h160, 1'b1, 1'b1, 32'h700);
    // lookup of a branch being allocated in the same cycle still misses
    cur_req = "R10";
    step(1'b1, 32'h18C, 1'b1, 1'b1, 32'h18C, 1'b1, 32'h800);
    look("R10", 32'h18C, 1'b1, 1'b1, 32'h800);

    // mixed traffic checked against the model on every clock
    cur_req = "R8";
    for (int i = 0; i < 2000; i++) begin
      logic [PC_W-1:0] a, b;
      a = {27'(($urandom % 4) + 1), 3'($urandom % 4), 2'b00};
      b = {27'(($urandom % 4) + 1), 3'($urandom % 4), 2'($urandom)};
      step(1'($urandom), a, 1'($urandom), 1'($urandom), b, 1'($urandom),
           PC_W'($urandom) & 32'hFFFF_FFFC);
    end
    step(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, '0);
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule